// File: doc/BRIEF.md
# Two-Client Cache Refill Arbiter

This block lets an instruction cache and a data cache share one 128-bit memory refill port. Each cache offers refill requests through its own valid/ready port. The arbiter picks one client, opens that client's ready, and forwards the client's command, address, write data and tag to memory. A client learns that it won only from its ready signal.

When both caches ask at once, the instruction cache wins. A cache line moves as four 128-bit beats. Once a client's first beat is accepted, the arbiter keeps the port for that client until all four beats are through, so beats from the two caches never interleave. Each outgoing tag is extended with one client bit. Memory returns that bit in the response tag, and the arbiter uses it to raise the response valid of the cache that issued the request.

Top module: `refill_arbiter`

## Requirements
- R1: After reset is released with no request pending, `ic_req_rdy`, `dc_req_rdy` and `mem_req_val` are all low, and no client holds the port.
- R2: With the port unlocked and both clients valid, the instruction client is granted and `dc_req_rdy` is low in that cycle.
- R3: A client's ready is high only when `mem_req_rdy` is high and that client holds the grant. At most one ready is high in any cycle. `mem_req_val` is high exactly when the grant holder has its request valid high.
- R4: The memory command fields follow the grant holder. For the data client, `mem_req_rw` (1 = write), the address and the write data are copied. For the instruction client, `mem_req_rw` is 0, the address is copied and the write data is all zeros. With no grant holder, all fields are zero.
- R5: `mem_req_tag` is one bit wider than a client tag. Its most significant bit names the client (0 = instruction, 1 = data), and its low bits carry the client's own tag.
- R6: A response with `mem_resp_val` high raises only the response valid of the client named by the most significant bit of `mem_resp_tag`. Both clients see `mem_resp_data` and the low tag bits.
- R7: After a client's first beat is accepted (`mem_req_val` and `mem_req_rdy` both high), only that client can be granted until four beats in total have been accepted. This holds even against a higher-priority request.
- R8: While locked, if the holder drops its request valid, `mem_req_val` is low and the other client's ready stays low.
- R9: With the port unlocked and no request valid, `mem_req_val` is low and the previous grant holder is cleared.
- R10: In the cycle after the fourth beat is accepted, the port is unlocked and priority arbitration applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ic_req_val | input | 1 | Instruction client request valid |
| ic_req_rdy | output | 1 | Instruction client request accepted |
| ic_req_addr | input | ADDR_W | Instruction client refill address |
| ic_req_tag | input | TAG_W | Instruction client tag |
| ic_resp_val | output | 1 | Response valid for the instruction client |
| ic_resp_data | output | DATA_W | Response data (shared) |
| ic_resp_tag | output | TAG_W | Response tag, client part |
| dc_req_val | input | 1 | Data client request valid |
| dc_req_rdy | output | 1 | Data client request accepted |
| dc_req_rw | input | 1 | Data client command, 1 = write |
| dc_req_addr | input | ADDR_W | Data client address |
| dc_req_data | input | DATA_W | Data client write data |
| dc_req_tag | input | TAG_W | Data client tag |
| dc_resp_val | output | 1 | Response valid for the data client |
| dc_resp_data | output | DATA_W | Response data (shared) |
| dc_resp_tag | output | TAG_W | Response tag, client part |
| mem_req_val | output | 1 | Memory request valid |
| mem_req_rdy | input | 1 | Memory ready to accept |
| mem_req_rw | output | 1 | Memory command, 1 = write |
| mem_req_addr | output | ADDR_W | Memory address |
| mem_req_data | output | DATA_W | Memory write data |
| mem_req_tag | output | TAG_W+1 | Client bit on top of the client tag |
| mem_resp_val | input | 1 | Memory response valid |
| mem_resp_data | input | DATA_W | Memory response data |
| mem_resp_tag | input | TAG_W+1 | Memory response tag |

## Verification
The reference model is driven with four request mixes, and each mix separates a different class of fault:
- Dense traffic from both clients with a stalling memory ready tests priority against the four-beat lock. A lock that releases early or late shows up as a grant to the wrong client.
- Sparse traffic leaves gaps in which the holder drops its valid and the port goes idle. This exposes grants that are not cleared, and valid forwarded from the wrong side.
- A data-only mix and an instruction-only mix check field forwarding, the instruction side's forced read, and the client bit in the tag.

In every mix, randomly tagged responses test the steering by the client bit.

// File: rtl/refill_arb_pkg.sv
package refill_arb_pkg;

  typedef enum logic {
    CL_INSTR = 1'b0,
    CL_DATA  = 1'b1
  } client_e;

  // True when beat index idx is the final beat of a transfer of `beats` beats.
  function automatic logic beat_is_last(input int idx, input int beats);
    return (idx + 1) >= beats;
  endfunction

  // Fixed priority: the instruction side wins whenever it is asking.
  function automatic client_e pick_winner(input logic ic_val);
    return ic_val ? CL_INSTR : CL_DATA;
  endfunction

endpackage

// File: rtl/refill_grant.sv
module refill_grant
  import refill_arb_pkg::*;
#(
  parameter int BEATS = 4,
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ic_val,
  input  logic             dc_val,
  input  logic             mem_rdy,
  output logic             grant_ic,
  output logic             grant_dc,
  output logic             fwd_val,
  output logic             accept,
  output logic             lock_active,
  output client_e          lock_owner,
  output logic [CNT_W-1:0] beat_idx
);

  logic             locked_q;
  client_e          owner_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_beat;
  client_e          winner;

  always_comb begin
    winner = pick_winner(ic_val);
    if (locked_q) begin
      grant_ic = (owner_q == CL_INSTR);
      grant_dc = (owner_q == CL_DATA);
    end else begin
      grant_ic = ic_val;
      grant_dc = dc_val & ~ic_val;
    end
    fwd_val   = (grant_ic & ic_val) | (grant_dc & dc_val);
    accept    = fwd_val & mem_rdy;
    last_beat = beat_is_last(int'(cnt_q), BEATS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      owner_q  <= CL_INSTR;
      cnt_q    <= '0;
    end else if (accept) begin
      if (last_beat) begin
        locked_q <= 1'b0;
        owner_q  <= CL_INSTR;
        cnt_q    <= '0;
      end else begin
        locked_q <= 1'b1;
        cnt_q    <= cnt_q + CNT_W'(1);
        if (!locked_q) owner_q <= winner;
      end
    end else if (!locked_q) begin
      owner_q <= CL_INSTR;
    end
  end

  assign lock_active = locked_q;
  assign lock_owner  = owner_q;
  assign beat_idx    = cnt_q;

endmodule

// File: rtl/refill_req_mux.sv
module refill_req_mux #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128,
  parameter int TAG_W  = 6
) (
  input  logic              grant_ic,
  input  logic              grant_dc,
  input  logic [ADDR_W-1:0] ic_addr,
  input  logic [TAG_W-1:0]  ic_tag,
  input  logic              dc_rw,
  input  logic [ADDR_W-1:0] dc_addr,
  input  logic [DATA_W-1:0] dc_data,
  input  logic [TAG_W-1:0]  dc_tag,
  output logic              mem_rw,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [TAG_W:0]    mem_tag
);

  function automatic logic [TAG_W:0] make_tag(input logic who, input logic [TAG_W-1:0] t);
    return {who, t};
  endfunction

  always_comb begin
    mem_rw   = 1'b0;
    mem_addr = '0;
    mem_data = '0;
    mem_tag  = '0;
    if (grant_dc) begin
      mem_rw   = dc_rw;
      mem_addr = dc_addr;
      mem_data = dc_data;
      mem_tag  = make_tag(1'b1, dc_tag);
    end else if (grant_ic) begin
      mem_addr = ic_addr;
      mem_tag  = make_tag(1'b0, ic_tag);
    end
  end

endmodule

// File: rtl/refill_resp_steer.sv
module refill_resp_steer #(
  parameter int DATA_W  = 128,
  parameter int TAG_W   = 6,
  parameter int CLIENTS = 2
) (
  input  logic              mem_resp_val,
  input  logic [DATA_W-1:0] mem_resp_data,
  input  logic [TAG_W:0]    mem_resp_tag,
  output logic [CLIENTS-1:0]            resp_val,
  output logic [CLIENTS-1:0][DATA_W-1:0] resp_data,
  output logic [CLIENTS-1:0][TAG_W-1:0]  resp_tag
);

  for (genvar c = 0; c < CLIENTS; c++) begin : g_client
    assign resp_val[c]  = mem_resp_val & (mem_resp_tag[TAG_W] == 1'(c));
    assign resp_data[c] = mem_resp_data;
    assign resp_tag[c]  = mem_resp_tag[TAG_W-1:0];
  end

endmodule

// File: rtl/refill_arbiter.sv
module refill_arbiter
  import refill_arb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128,
  parameter int TAG_W  = 6,
  parameter int BEATS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ic_req_val,
  output logic              ic_req_rdy,
  input  logic [ADDR_W-1:0] ic_req_addr,
  input  logic [TAG_W-1:0]  ic_req_tag,
  output logic              ic_resp_val,
  output logic [DATA_W-1:0] ic_resp_data,
  output logic [TAG_W-1:0]  ic_resp_tag,
  input  logic              dc_req_val,
  output logic              dc_req_rdy,
  input  logic              dc_req_rw,
  input  logic [ADDR_W-1:0] dc_req_addr,
  input  logic [DATA_W-1:0] dc_req_data,
  input  logic [TAG_W-1:0]  dc_req_tag,
  output logic              dc_resp_val,
  output logic [DATA_W-1:0] dc_resp_data,
  output logic [TAG_W-1:0]  dc_resp_tag,
  output logic              mem_req_val,
  input  logic              mem_req_rdy,
  output logic              mem_req_rw,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_data,
  output logic [TAG_W:0]    mem_req_tag,
  input  logic              mem_resp_val,
  input  logic [DATA_W-1:0] mem_resp_data,
  input  logic [TAG_W:0]    mem_resp_tag
);

  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  // Internal events, brought out by name for the checker.
  logic             grant_ic;
  logic             grant_dc;
  logic             accept;
  logic             lock_active;
  client_e          lock_owner;
  logic [CNT_W-1:0] beat_idx;

  logic [1:0]             rv;
  logic [1:0][DATA_W-1:0] rd;
  logic [1:0][TAG_W-1:0]  rt;

  refill_grant #(.BEATS(BEATS)) u_grant (
    .clk         (clk),
    .rst_n       (rst_n),
    .ic_val      (ic_req_val),
    .dc_val      (dc_req_val),
    .mem_rdy     (mem_req_rdy),
    .grant_ic    (grant_ic),
    .grant_dc    (grant_dc),
    .fwd_val     (mem_req_val),
    .accept      (accept),
    .lock_active (lock_active),
    .lock_owner  (lock_owner),
    .beat_idx    (beat_idx)
  );

  assign ic_req_rdy = mem_req_rdy & grant_ic;
  assign dc_req_rdy = mem_req_rdy & grant_dc;

  refill_req_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_mux (
    .grant_ic (grant_ic),
    .grant_dc (grant_dc),
    .ic_addr  (ic_req_addr),
    .ic_tag   (ic_req_tag),
    .dc_rw    (dc_req_rw),
    .dc_addr  (dc_req_addr),
    .dc_data  (dc_req_data),
    .dc_tag   (dc_req_tag),
    .mem_rw   (mem_req_rw),
    .mem_addr (mem_req_addr),
    .mem_data (mem_req_data),
    .mem_tag  (mem_req_tag)
  );

  refill_resp_steer #(.DATA_W(DATA_W), .TAG_W(TAG_W), .CLIENTS(2)) u_steer (
    .mem_resp_val  (mem_resp_val),
    .mem_resp_data (mem_resp_data),
    .mem_resp_tag  (mem_resp_tag),
    .resp_val      (rv),
    .resp_data     (rd),
    .resp_tag      (rt)
  );

  assign ic_resp_val  = rv[0];
  assign ic_resp_data = rd[0];
  assign ic_resp_tag  = rt[0];
  assign dc_resp_val  = rv[1];
  assign dc_resp_data = rd[1];
  assign dc_resp_tag  = rt[1];

endmodule

// File: rtl/refill_arbiter_chk.sv
module refill_arbiter_chk
  import refill_arb_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int BEATS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ic_req_val,
  input logic           ic_req_rdy,
  input logic           dc_req_val,
  input logic           dc_req_rdy,
  input logic           mem_req_val,
  input logic           mem_req_rdy,
  input logic           mem_req_rw,
  input logic [TAG_W:0] mem_req_tag,
  input logic           mem_resp_val,
  input logic [TAG_W:0] mem_resp_tag,
  input logic           ic_resp_val,
  input logic           dc_resp_val,
  input logic           lock_active,
  input client_e        lock_owner
);

  // Accepted beats modulo the line length, counted independently of the grant logic.
  int acc_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) acc_cnt <= 0;
    else if (mem_req_val && mem_req_rdy) acc_cnt <= (acc_cnt + 1 >= BEATS) ? 0 : acc_cnt + 1;
  end

  AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ic_req_rdy, dc_req_rdy}));  // R3
  AST_READY_NEEDS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (ic_req_rdy || dc_req_rdy) |-> mem_req_rdy);  // R3
  AST_INSTR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_active && ic_req_val && dc_req_val) |-> !dc_req_rdy);  // R2
  AST_DATA_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_active && lock_owner == CL_DATA) |-> !ic_req_rdy);  // R7
  AST_INSTR_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_active && lock_owner == CL_INSTR) |-> !dc_req_rdy);  // R7
  AST_LOCK_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_active == (acc_cnt != 0));  // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ic_req_val && !dc_req_val) |-> !mem_req_val);  // R9
  AST_INSTR_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_val && !mem_req_tag[TAG_W]) |-> !mem_req_rw);  // R4
  AST_TAG_NAMES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_req_rdy && dc_req_val) |-> mem_req_tag[TAG_W]);  // R5
  AST_RESP_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_resp_val && mem_resp_tag[TAG_W]) |-> (dc_resp_val && !ic_resp_val));  // R6
  AST_RESP_TO_INSTR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_resp_val && !mem_resp_tag[TAG_W]) |-> (ic_resp_val && !dc_resp_val));  // R6

endmodule

bind refill_arbiter refill_arbiter_chk #(.TAG_W(TAG_W), .BEATS(BEATS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ic_req_val   (ic_req_val),
  .ic_req_rdy   (ic_req_rdy),
  .dc_req_val   (dc_req_val),
  .dc_req_rdy   (dc_req_rdy),
  .mem_req_val  (mem_req_val),
  .mem_req_rdy  (mem_req_rdy),
  .mem_req_rw   (mem_req_rw),
  .mem_req_tag  (mem_req_tag),
  .mem_resp_val (mem_resp_val),
  .mem_resp_tag (mem_resp_tag),
  .ic_resp_val  (ic_resp_val),
  .dc_resp_val  (dc_resp_val),
  .lock_active  (lock_active),
  .lock_owner   (lock_owner)
);

// File: tb/test_refill_arbiter.sv
module test_refill_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 128;
  localparam int TAG_W  = 6;
  localparam int BEATS  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ic_req_val = 1'b0, ic_req_rdy;
  logic [ADDR_W-1:0] ic_req_addr = '0;
  logic [TAG_W-1:0]  ic_req_tag = '0;
  logic              ic_resp_val;
  logic [DATA_W-1:0] ic_resp_data;
  logic [TAG_W-1:0]  ic_resp_tag;
  logic              dc_req_val = 1'b0, dc_req_rdy, dc_req_rw = 1'b0;
  logic [ADDR_W-1:0] dc_req_addr = '0;
  logic [DATA_W-1:0] dc_req_data = '0;
  logic [TAG_W-1:0]  dc_req_tag = '0;
  logic              dc_resp_val;
  logic [DATA_W-1:0] dc_resp_data;
  logic [TAG_W-1:0]  dc_resp_tag;
  logic              mem_req_val, mem_req_rdy = 1'b0, mem_req_rw;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [DATA_W-1:0] mem_req_data;
  logic [TAG_W:0]    mem_req_tag;
  logic              mem_resp_val = 1'b0;
  logic [DATA_W-1:0] mem_resp_data = '0;
  logic [TAG_W:0]    mem_resp_tag = '0;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Reference model state: lock flag, owner (0 instr / 1 data), beats taken.
  bit m_locked = 1'b0;
  bit m_owner = 1'b0;
  int m_beats = 0;
  bit m_just_freed = 1'b0;
  bit m_first = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refill_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .BEATS(BEATS)) i_refill_arbiter (
    .clk(clk), .rst_n(rst_n),
    .ic_req_val(ic_req_val), .ic_req_rdy(ic_req_rdy), .ic_req_addr(ic_req_addr), .ic_req_tag(ic_req_tag),
    .ic_resp_val(ic_resp_val), .ic_resp_data(ic_resp_data), .ic_resp_tag(ic_resp_tag),
    .dc_req_val(dc_req_val), .dc_req_rdy(dc_req_rdy), .dc_req_rw(dc_req_rw), .dc_req_addr(dc_req_addr),
    .dc_req_data(dc_req_data), .dc_req_tag(dc_req_tag),
    .dc_resp_val(dc_resp_val), .dc_resp_data(dc_resp_data), .dc_resp_tag(dc_resp_tag),
    .mem_req_val(mem_req_val), .mem_req_rdy(mem_req_rdy), .mem_req_rw(mem_req_rw),
    .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data), .mem_req_tag(mem_req_tag),
    .mem_resp_val(mem_resp_val), .mem_resp_data(mem_resp_data), .mem_resp_tag(mem_resp_tag)
  );

  task automatic chk(input string req, input string what, input logic [159:0] act, input logic [159:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] rnd_data();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Compare every output with the model, then advance the model by one clock.
  task automatic compare_and_step();
    bit g_ic, g_dc, e_val, both;
    string lab_rdy, lab_val;
    g_ic  = m_locked ? (m_owner == 1'b0) : ic_req_val;
    g_dc  = m_locked ? (m_owner == 1'b1) : (dc_req_val && !ic_req_val);
    e_val = (g_ic && ic_req_val) || (g_dc && dc_req_val);
    both  = ic_req_val && dc_req_val;
    if (m_first) lab_rdy = "R1";
    else if (m_just_freed) lab_rdy = "R10";
    else if (m_locked) lab_rdy = "R7";
    else if (both) lab_rdy = "R2";
    else lab_rdy = "R3";
    if (m_first) lab_val = "R1";
    else if (m_locked && !e_val) lab_val = "R8";
    else if (!m_locked && !ic_req_val && !dc_req_val) lab_val = "R9";
    else lab_val = "R3";
    chk(lab_rdy, "ic_req_rdy", 160'(ic_req_rdy), 160'(mem_req_rdy && g_ic));
    chk(lab_rdy, "dc_req_rdy", 160'(dc_req_rdy), 160'(mem_req_rdy && g_dc));
    chk(lab_val, "mem_req_val", 160'(mem_req_val), 160'(e_val));
    if (g_dc) begin
      chk("R4", "mem_req_rw", 160'(mem_req_rw), 160'(dc_req_rw));
      chk("R4", "mem_req_addr", 160'(mem_req_addr), 160'(dc_req_addr));
      chk("R4", "mem_req_data", 160'(mem_req_data), 160'(dc_req_data));
      chk("R5", "mem_req_tag", 160'(mem_req_tag), 160'({1'b1, dc_req_tag}));
    end else if (g_ic) begin
      chk("R4", "mem_req_rw", 160'(mem_req_rw), 160'(0));
      chk("R4", "mem_req_addr", 160'(mem_req_addr), 160'(ic_req_addr));
      chk("R4", "mem_req_data", 160'(mem_req_data), 160'(0));
      chk("R5", "mem_req_tag", 160'(mem_req_tag), 160'({1'b0, ic_req_tag}));
    end else begin
      chk("R4", "idle fields", 160'({mem_req_rw, mem_req_addr, mem_req_data, mem_req_tag}), 160'(0));
    end
    chk("R6", "ic_resp_val", 160'(ic_resp_val), 160'(mem_resp_val && !mem_resp_tag[TAG_W]));
    chk("R6", "dc_resp_val", 160'(dc_resp_val), 160'(mem_resp_val && mem_resp_tag[TAG_W]));
    chk("R6", "resp data/tag", 160'({ic_resp_tag, dc_resp_tag}), 160'({mem_resp_tag[TAG_W-1:0], mem_resp_tag[TAG_W-1:0]}));
    chk("R6", "dc_resp_data", 160'(dc_resp_data), 160'(mem_resp_data));
    m_first = 1'b0;
    m_just_freed = 1'b0;
    if (e_val && mem_req_rdy) begin
      if (!m_locked) begin
        m_owner = g_dc;
        m_beats = 1;
        m_locked = 1'b1;
      end else begin
        m_beats++;
      end
      if (m_beats >= BEATS) begin
        m_locked = 1'b0;
        m_beats = 0;
        m_just_freed = 1'b1;
      end
    end
  endtask

  task automatic run_mix(input int p_ic, input int p_dc, input int p_rdy, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      ic_req_val    = ($urandom_range(99) < p_ic);
      dc_req_val    = ($urandom_range(99) < p_dc);
      mem_req_rdy   = ($urandom_range(99) < p_rdy);
      ic_req_addr   = $urandom;
      ic_req_tag    = TAG_W'($urandom);
      dc_req_rw     = 1'($urandom);
      dc_req_addr   = $urandom;
      dc_req_data   = rnd_data();
      dc_req_tag    = TAG_W'($urandom);
      mem_resp_val  = 1'($urandom);
      mem_resp_data = rnd_data();
      mem_resp_tag  = (TAG_W+1)'($urandom);
      #1;
      compare_and_step();
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_first = 1'b1;
    #1;
    compare_and_step();          // R1: idle after reset
    run_mix(90, 90, 70, 400);    // dense, both clients: R2, R7, R10
    run_mix(30, 30, 50, 400);    // sparse: R8, R9
    run_mix(0, 80, 100, 300);    // data only: R4, R5
    run_mix(80, 0, 40, 300);     // instruction only: R4, R5
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule